// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block is one DMA channel. It moves a run of elements between a fixed device address and an incrementing memory address, and all of its traffic goes through one word-wide memory master port. It has two start modes. In single-shot mode the four parameter registers loaded by the host describe the transfer. In chained mode only the link register is used: it points at the first of a list of four-word descriptors that the engine reads from memory.

Each descriptor, and the register set, holds four words: the device address, the memory address, a size word and a link word. The size word packs an element-width code next to an element count. The two low bits of the link word say whether the chain continues and whether a completion pulse is wanted. The engine checks every descriptor before it moves any data. A bad width code, or a count above the limit for that width, raises an error pulse and stops the channel. A 2-bit state output shows what the engine is doing. A mode input of zero aborts the transfer at any time.

Top module: `lnk_dma_chan`

## Requirements
- R1: With `cfgWe` high, `cfgSel` picks the register that takes `cfgData` on the clock edge: 0 device address, 1 memory address, 2 size word, 3 link word.
- R2: A `startReq` pulse while idle with `mode`=2 (single-shot) runs one transfer from the four registers, and the channel then goes back to idle.
- R3: When `dirToDev` (sampled at start) is 1, each element is read from the memory address and written to the device address. When it is 0, each element is read from the device address and written to the memory address. The device address stays fixed and the memory address advances by the element size.
- R4: Size word bits [13:12] select the width: 3 is one byte (data masked to bits [7:0]), 2 is two bytes (masked to [15:0]), 0 is four bytes. Bits [11:0] give the element count, and a count of 0 moves nothing.
- R5: Width code 1 is an error. A count above 0x3FF for one- or two-byte width, or above 0x7FF for four-byte width, is also an error. On an error `errPulse` is high for one cycle, nothing is written, and the channel goes idle.
- R6: A `startReq` pulse while idle with `mode`=1 (chained) reads four words from the link register's address with bits [1:0] cleared, at offsets +0, +4, +8 and +12. These become the device address, memory address, size word and link word.
- R7: Link word bits [1:0]: bit 1 set means the engine goes on to fetch the descriptor at the upper bits (chained mode only). Bit 0 set gives a one-cycle `donePulse` when that descriptor finishes.
- R8: `stateCode` is 0 when idle, 1 while reading descriptor words, 2 while checking or ending a descriptor, and 3 while moving data.
- R9: A `startReq` while the channel is not idle is ignored, and the running transfer carries on unchanged.
- R10: While `mode` is 0 the channel is idle from the next cycle on and issues no memory requests.
- R11: After reset the channel is idle, with no request and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Parameter register write strobe |
| cfgSel | input | 2 | Parameter register select |
| cfgData | input | 32 | Parameter register write data |
| mode | input | 2 | 0 off/abort, 1 chained, 2 single-shot |
| startReq | input | 1 | Start request pulse |
| dirToDev | input | 1 | 1: memory to device, 0: device to memory |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWe | output | 1 | Access is a write |
| memAddr | output | 32 | Access address |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Access done; read data valid |
| memRdata | input | 32 | Read data |
| stateCode | output | 2 | Channel state code |
| donePulse | output | 1 | Descriptor completion pulse |
| errPulse | output | 1 | Descriptor error pulse |

## Verification
Some rules are checked on every cycle by assertions: an abort forces idle on the next cycle, the idle state never requests memory, an error pulse is always followed by idle, the two pulses never fire together, and a data read waiting for its acknowledge is not disturbed by a new start. Other behaviour can only be shown by the bench's scenarios. These are the data each element delivers under the width masks, the address stepping, the order of the descriptor fields, how links and interrupt flags are followed across a chain, and the exact count boundaries that split legal descriptors from illegal ones.

// File: rtl/lnkdma_pkg.sv
package lnkdma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_CHECK,
    S_RD,
    S_WR,
    S_END
  } ctlState_e;

  typedef enum logic [1:0] {
    ADR_DESC,
    ADR_SRC,
    ADR_DST
  } adrSel_e;

  typedef struct packed {
    logic    loadSingle;
    logic    loadHead;
    logic    loadLink;
    logic    takeWord;
    logic    takeData;
    logic    stepElem;
    adrSel_e adrSel;
  } dpStrobe_t;

  localparam logic [1:0] MODE_OFF    = 2'd0;
  localparam logic [1:0] MODE_CHAIN  = 2'd1;
  localparam logic [1:0] MODE_SINGLE = 2'd2;

  localparam logic [1:0] WCODE_B4 = 2'd0;
  localparam logic [1:0] WCODE_B2 = 2'd2;
  localparam logic [1:0] WCODE_B1 = 2'd3;

endpackage

// File: rtl/lnkdma_dpath.sv
module lnkdma_dpath
  import lnkdma_pkg::*;
#(
  parameter int DW         = 32,
  parameter int CNT_W      = 12,
  parameter int NARROW_MAX = 'h3FF,
  parameter int WIDE_MAX   = 'h7FF
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [1:0]      cfgSel,
  input  logic [DW-1:0]   cfgData,
  input  logic            dirToDev,
  input  dpStrobe_t       stb,
  input  logic [DW-1:0]   memRdata,
  output logic [DW-1:0]   memAddr,
  output logic [DW-1:0]   memWdata,
  output logic            descValid,
  output logic            countZero,
  output logic            lastElem,
  output logic            fetchLast,
  output logic            irqFlag,
  output logic            followFlag
);

  localparam int NREG = 4;
  localparam logic [CNT_W-1:0] NarrowLim = NARROW_MAX[CNT_W-1:0];
  localparam logic [CNT_W-1:0] WideLim   = WIDE_MAX[CNT_W-1:0];

  logic [DW-1:0]    cfgReg [NREG];
  logic [DW-1:0]    wDev, wMem, wSize, wNext, ptr, dataReg;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       fetchIdx;
  logic             dirReg;

  logic [1:0]       wCode;
  logic [CNT_W-1:0] wCount;
  logic [2:0]       elemBytes;
  logic             unusedSize;

  assign wCode      = wSize[CNT_W+1:CNT_W];
  assign wCount     = wSize[CNT_W-1:0];
  assign unusedSize = ^wSize[DW-1:CNT_W+2];

  // host-side parameter registers, one per select value
  for (genvar g = 0; g < NREG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN)                             cfgReg[g] <= '0;
      else if (cfgWe && cfgSel == 2'(g))     cfgReg[g] <= cfgData;
    end
  end

  always_comb begin
    case (wCode)
      WCODE_B1: begin elemBytes = 3'd1; descValid = (wCount <= NarrowLim); end
      WCODE_B2: begin elemBytes = 3'd2; descValid = (wCount <= NarrowLim); end
      WCODE_B4: begin elemBytes = 3'd4; descValid = (wCount <= WideLim);   end
      default:  begin elemBytes = 3'd4; descValid = 1'b0;                  end
    endcase
  end

  assign countZero  = (cnt == '0);
  assign lastElem   = (cnt == CNT_W'(1));
  assign fetchLast  = (fetchIdx == 2'd3);
  assign irqFlag    = wNext[0];
  assign followFlag = wNext[1];

  always_comb begin
    case (stb.adrSel)
      ADR_SRC: memAddr = dirReg ? wMem : wDev;
      ADR_DST: memAddr = dirReg ? wDev : wMem;
      default: memAddr = ptr;
    endcase
  end

  always_comb begin
    case (wCode)
      WCODE_B1: memWdata = dataReg & {{(DW-8){1'b0}}, 8'hFF};
      WCODE_B2: memWdata = dataReg & {{(DW-16){1'b0}}, 16'hFFFF};
      default:  memWdata = dataReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wDev     <= '0;
      wMem     <= '0;
      wSize    <= '0;
      wNext    <= '0;
      ptr      <= '0;
      dataReg  <= '0;
      cnt      <= '0;
      fetchIdx <= '0;
      dirReg   <= 1'b0;
    end else begin
      if (stb.loadSingle) begin
        wDev   <= cfgReg[0];
        wMem   <= cfgReg[1];
        wSize  <= cfgReg[2];
        wNext  <= cfgReg[3];
        cnt    <= cfgReg[2][CNT_W-1:0];
        dirReg <= dirToDev;
      end
      if (stb.loadHead) begin
        ptr      <= {cfgReg[3][DW-1:2], 2'b00};
        fetchIdx <= '0;
        dirReg   <= dirToDev;
      end
      if (stb.loadLink) begin
        ptr      <= {wNext[DW-1:2], 2'b00};
        fetchIdx <= '0;
      end
      if (stb.takeWord) begin
        case (fetchIdx)
          2'd0: wDev <= memRdata;
          2'd1: wMem <= memRdata;
          2'd2: begin wSize <= memRdata; cnt <= memRdata[CNT_W-1:0]; end
          default: wNext <= memRdata;
        endcase
        fetchIdx <= fetchIdx + 2'd1;
        ptr      <= ptr + DW'(4);
      end
      if (stb.takeData) dataReg <= memRdata;
      if (stb.stepElem) begin
        wMem <= wMem + {{(DW-3){1'b0}}, elemBytes};
        cnt  <= cnt - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/lnkdma_ctl.sv
module lnkdma_ctl
  import lnkdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] mode,
  input  logic       startReq,
  input  logic       memAck,
  input  logic       descValid,
  input  logic       countZero,
  input  logic       lastElem,
  input  logic       fetchLast,
  input  logic       irqFlag,
  input  logic       followFlag,
  output dpStrobe_t  stb,
  output logic       memReq,
  output logic       memWe,
  output logic [1:0] stateCode,
  output logic       donePulse,
  output logic       errPulse
);

  ctlState_e cur, nxt;
  logic      chainMode, nxtChain;
  logic      live;

  assign live = (mode != MODE_OFF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur       <= S_IDLE;
      chainMode <= 1'b0;
    end else begin
      cur       <= nxt;
      chainMode <= nxtChain;
    end
  end

  always_comb begin
    nxt       = cur;
    nxtChain  = chainMode;
    stb       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    donePulse = 1'b0;
    errPulse  = 1'b0;
    if (!live) begin
      nxt = S_IDLE;
    end else begin
      case (cur)
        S_IDLE: begin
          if (startReq && mode == MODE_SINGLE) begin
            stb.loadSingle = 1'b1;
            nxtChain       = 1'b0;
            nxt            = S_CHECK;
          end else if (startReq && mode == MODE_CHAIN) begin
            stb.loadHead = 1'b1;
            nxtChain     = 1'b1;
            nxt          = S_FETCH;
          end
        end
        S_FETCH: begin
          memReq     = 1'b1;
          stb.adrSel = ADR_DESC;
          if (memAck) begin
            stb.takeWord = 1'b1;
            if (fetchLast) nxt = S_CHECK;
          end
        end
        S_CHECK: begin
          if (!descValid) begin
            errPulse = 1'b1;
            nxt      = S_IDLE;
          end else if (countZero) begin
            nxt = S_END;
          end else begin
            nxt = S_RD;
          end
        end
        S_RD: begin
          memReq     = 1'b1;
          stb.adrSel = ADR_SRC;
          if (memAck) begin
            stb.takeData = 1'b1;
            nxt          = S_WR;
          end
        end
        S_WR: begin
          memReq     = 1'b1;
          memWe      = 1'b1;
          stb.adrSel = ADR_DST;
          if (memAck) begin
            stb.stepElem = 1'b1;
            nxt          = lastElem ? S_END : S_RD;
          end
        end
        S_END: begin
          donePulse = irqFlag;
          if (chainMode && followFlag) begin
            stb.loadLink = 1'b1;
            nxt          = S_FETCH;
          end else begin
            nxt = S_IDLE;
          end
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (cur)
      S_FETCH:       stateCode = 2'd1;
      S_CHECK, S_END: stateCode = 2'd2;
      S_RD, S_WR:    stateCode = 2'd3;
      default:       stateCode = 2'd0;
    endcase
  end

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF) |=> (stateCode == 2'd0));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 2'd0) |-> !memReq);

  // R5
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> (stateCode == 2'd0));

  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({donePulse, errPulse}));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cur == S_RD && !memAck && live) |=> (cur == S_RD));

endmodule

// File: rtl/lnk_dma_chan.sv
module lnk_dma_chan
  import lnkdma_pkg::*;
#(
  parameter int DW         = 32,
  parameter int CNT_W      = 12,
  parameter int NARROW_MAX = 'h3FF,
  parameter int WIDE_MAX   = 'h7FF
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [1:0]    cfgSel,
  input  logic [DW-1:0] cfgData,
  input  logic [1:0]    mode,
  input  logic          startReq,
  input  logic          dirToDev,
  output logic          memReq,
  output logic          memWe,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic          memAck,
  input  logic [DW-1:0] memRdata,
  output logic [1:0]    stateCode,
  output logic          donePulse,
  output logic          errPulse
);

  dpStrobe_t stb;
  logic descValid, countZero, lastElem, fetchLast, irqFlag, followFlag;

  lnkdma_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .mode       (mode),
    .startReq   (startReq),
    .memAck     (memAck),
    .descValid  (descValid),
    .countZero  (countZero),
    .lastElem   (lastElem),
    .fetchLast  (fetchLast),
    .irqFlag    (irqFlag),
    .followFlag (followFlag),
    .stb        (stb),
    .memReq     (memReq),
    .memWe      (memWe),
    .stateCode  (stateCode),
    .donePulse  (donePulse),
    .errPulse   (errPulse)
  );

  lnkdma_dpath #(
    .DW         (DW),
    .CNT_W      (CNT_W),
    .NARROW_MAX (NARROW_MAX),
    .WIDE_MAX   (WIDE_MAX)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgSel     (cfgSel),
    .cfgData    (cfgData),
    .dirToDev   (dirToDev),
    .stb        (stb),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .descValid  (descValid),
    .countZero  (countZero),
    .lastElem   (lastElem),
    .fetchLast  (fetchLast),
    .irqFlag    (irqFlag),
    .followFlag (followFlag)
  );

endmodule

// File: tb/tb_lnk_dma_chan.sv
module tb_lnk_dma_chan;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [31:0] cfgData = '0;
  logic [1:0]  mode = 2'd2;
  logic        startReq = 1'b0;
  logic        dirToDev = 1'b0;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;
  logic [1:0]  stateCode;
  logic        donePulse, errPulse;

  int checks = 0;
  int errors = 0;
  int wrCnt = 0;
  int doneCnt = 0;
  int errCnt = 0;
  int region = 0;
  bit seen [4];

  logic [31:0] mem [logic [31:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  lnk_dma_chan dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .mode(mode), .startReq(startReq), .dirToDev(dirToDev),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata),
    .stateCode(stateCode), .donePulse(donePulse), .errPulse(errPulse)
  );

  function automatic logic [31:0] pat(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] rdw(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return pat(a);
  endfunction

  function automatic int esz(logic [1:0] code);
    return (code == 2'd3) ? 1 : (code == 2'd2) ? 2 : 4;
  endfunction

  function automatic logic [31:0] maskv(logic [1:0] code, logic [31:0] v);
    if (code == 2'd3) return v & 32'hFF;
    if (code == 2'd2) return v & 32'hFFFF;
    return v;
  endfunction

  // memory and monitors, all at the falling edge
  always @(negedge clk) begin
    if (memAck) memAck = 1'b0;
    else if (memReq) begin
      if (memWe) begin
        mem[memAddr] = memWdata;
        wrCnt++;
      end else begin
        memRdata = rdw(memAddr);
      end
      memAck = 1'b1;
    end
    if (donePulse) doneCnt++;
    if (errPulse)  errCnt++;
    seen[stateCode] = 1'b1;
  end

  task automatic checkEq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [1:0] sel, logic [31:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = val;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (stateCode != 2'd0 && n < 60000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic runSingle(string req, bit dir, logic [1:0] code, int cnt,
                           logic [1:0] flg, bit expErr);
    logic [31:0] devA, memA, sz;
    int w0, d0, e0, bad;
    devA = 32'hF000_0000 + 32'(region) * 32'h100;
    memA = 32'h0010_0000 + 32'(region) * 32'h1_0000;
    region++;
    sz = (32'(code) << 12) | (32'(cnt) & 32'hFFF);
    cfgWrite(2'd0, devA);
    cfgWrite(2'd1, memA);
    cfgWrite(2'd2, sz);
    cfgWrite(2'd3, {30'd0, flg});
    dirToDev = dir;
    mode = 2'd2;
    w0 = wrCnt; d0 = doneCnt; e0 = errCnt;
    pulseStart();
    // R8: single-shot first shows the checking state
    checkEq("R8", "state after single start", {30'd0, stateCode}, 32'd2);
    waitIdle();
    @(negedge clk);
    checkEq("R2", "idle after run", {30'd0, stateCode}, 32'd0);
    if (expErr) begin
      checkEq("R5", "error pulses", 32'(errCnt - e0), 32'd1);
      checkEq("R5", "writes on error", 32'(wrCnt - w0), 32'd0);
    end else begin
      checkEq("R5", "no error pulse", 32'(errCnt - e0), 32'd0);
      checkEq("R2", "write count", 32'(wrCnt - w0), 32'(cnt));
      checkEq("R7", "done pulses", 32'(doneCnt - d0), {31'd0, flg[0]});
      if (dir && cnt > 0) begin
        checkEq("R3", "device final data", rdw(devA),
                maskv(code, pat(memA + 32'((cnt - 1) * esz(code)))));
      end else if (!dir) begin
        bad = 0;
        for (int i = 0; i < cnt; i++)
          if (rdw(memA + 32'(i * esz(code))) !== maskv(code, pat(devA))) bad++;
        checkEq("R4", "memory element mismatches", 32'(bad), 32'd0);
      end
    end
  endtask

  task automatic putDesc(logic [31:0] at, logic [31:0] dv, logic [31:0] ma,
                         logic [31:0] sz, logic [31:0] nx);
    mem[at] = dv; mem[at + 4] = ma; mem[at + 8] = sz; mem[at + 12] = nx;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] base, dA, mA [3], dev3 [3];
    int cnts [3];
    int w0, d0, e0, bad;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    // R11
    checkEq("R11", "reset state", {30'd0, stateCode}, 32'd0);
    checkEq("R11", "reset request", {31'd0, memReq}, 32'd0);
    checkEq("R11", "reset pulses", {30'd0, donePulse, errPulse}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4: random single-shot transfers
    for (int k = 0; k < 8; k++) begin
      logic [1:0] code;
      int pick;
      pick = int'($urandom % 3);
      code = (pick == 0) ? 2'd3 : (pick == 1) ? 2'd2 : 2'd0;
      runSingle("R3", 1'($urandom), code, 1 + int'($urandom % 40), 2'($urandom), 1'b0);
    end

    // R4: zero count moves nothing
    runSingle("R4", 1'b0, 2'd0, 0, 2'd1, 1'b0);
    // R5: width code and count boundaries
    runSingle("R5", 1'b0, 2'd1, 4, 2'd0, 1'b1);
    runSingle("R5", 1'b0, 2'd3, 'h400, 2'd0, 1'b1);
    runSingle("R5", 1'b1, 2'd2, 'h3FF, 2'd1, 1'b0);
    runSingle("R5", 1'b0, 2'd0, 'h800, 2'd0, 1'b1);
    runSingle("R5", 1'b0, 2'd0, 'h7FF, 2'd0, 1'b0);

    // R6 R7 R8: three-descriptor chain
    base = 32'h0800_0000;
    for (int k = 0; k < 3; k++) begin
      dev3[k] = 32'hE000_0000 + 32'(k) * 32'h40;
      mA[k]   = 32'h0900_0000 + 32'(k) * 32'h1000;
      cnts[k] = 3 + k * 2;
    end
    putDesc(base,       dev3[0], mA[0], (32'd2 << 12) | 32'(cnts[0]), (base + 32'h40) | 32'd3);
    putDesc(base + 'h40, dev3[1], mA[1], (32'd0 << 12) | 32'(cnts[1]), (base + 32'h80) | 32'd2);
    putDesc(base + 'h80, dev3[2], mA[2], (32'd3 << 12) | 32'(cnts[2]), 32'd1);
    cfgWrite(2'd3, base | 32'd3);
    dirToDev = 1'b0;
    mode = 2'd1;
    for (int s = 0; s < 4; s++) seen[s] = 1'b0;
    w0 = wrCnt; d0 = doneCnt;
    pulseStart();
    checkEq("R8", "state after chain start", {30'd0, stateCode}, 32'd1);
    waitIdle();
    @(negedge clk);
    checkEq("R7", "chain writes", 32'(wrCnt - w0), 32'(cnts[0] + cnts[1] + cnts[2]));
    checkEq("R7", "chain done pulses", 32'(doneCnt - d0), 32'd2);
    checkEq("R8", "states seen 1/2/3", {29'd0, seen[1], seen[2], seen[3]}, 32'd7);
    bad = 0;
    for (int k = 0; k < 3; k++) begin
      logic [1:0] c;
      c = (k == 0) ? 2'd2 : (k == 1) ? 2'd0 : 2'd3;
      for (int i = 0; i < cnts[k]; i++)
        if (rdw(mA[k] + 32'(i * esz(c))) !== maskv(c, pat(dev3[k]))) bad++;
    end
    checkEq("R6", "chain element mismatches", 32'(bad), 32'd0);

    // R5 R7: bad descriptor in the middle of a chain stops it
    base = 32'h0A00_0000;
    putDesc(base,       32'hE100_0000, 32'h0B00_0000, 32'd5, (base + 32'h20) | 32'd2);
    putDesc(base + 'h20, 32'hE100_0040, 32'h0B00_1000, (32'd1 << 12) | 32'd5, 32'd1);
    cfgWrite(2'd3, base);
    w0 = wrCnt; d0 = doneCnt; e0 = errCnt;
    pulseStart();
    waitIdle();
    @(negedge clk);
    checkEq("R5", "chain error pulse", 32'(errCnt - e0), 32'd1);
    checkEq("R5", "chain writes before error", 32'(wrCnt - w0), 32'd5);
    checkEq("R7", "chain error no done", 32'(doneCnt - d0), 32'd0);

    // R9: start while busy is ignored
    dA = 32'hD000_0000;
    cfgWrite(2'd0, dA);
    cfgWrite(2'd1, 32'h0C00_0000);
    cfgWrite(2'd2, 32'd30);
    cfgWrite(2'd3, 32'd0);
    dirToDev = 1'b0;
    mode = 2'd2;
    w0 = wrCnt;
    pulseStart();
    repeat (10) @(negedge clk);
    mode = 2'd1;
    pulseStart();
    mode = 2'd2;
    pulseStart();
    waitIdle();
    @(negedge clk);
    checkEq("R9", "writes with extra starts", 32'(wrCnt - w0), 32'd30);
    checkEq("R9", "last element data", rdw(32'h0C00_0000 + 32'd116), pat(dA));

    // R10: abort
    cfgWrite(2'd2, 32'd100);
    cfgWrite(2'd1, 32'h0D00_0000);
    w0 = wrCnt;
    pulseStart();
    repeat (20) @(negedge clk);
    mode = 2'd0;
    @(negedge clk);
    checkEq("R10", "idle after abort", {30'd0, stateCode}, 32'd0);
    checkEq("R10", "no request after abort", {31'd0, memReq}, 32'd0);
    e0 = wrCnt;
    repeat (10) @(negedge clk);
    checkEq("R10", "no writes after abort", 32'(wrCnt - e0), 32'd0);
    checkEq("R10", "transfer cut short", {31'd0, (wrCnt - w0) < 100}, 32'd1);
    mode = 2'd2;

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule